// File: doc/BRIEF.md
# Channelized Segmented Frame Tracker

This block watches a receive bus that delivers twelve 16-byte segments per beat. Every valid beat belongs to a single channel, named by a channel number. Each segment carries its own enable, start marker, end marker and empty-byte count. The tracker keeps an in-frame bit and a running byte length for every channel. A frame may therefore open in one beat of a channel and close in a later beat of that channel, with beats of other channels in between.

Within a beat the segments are taken in ascending order. One beat can close a frame, sit idle for a few segments, and then open the next frame. For every frame that closes, the tracker reports its byte length on the lane of the closing segment. It raises pulse flags for four faults: a start inside a frame, an end with no frame open, a data segment outside any frame, and a completed frame shorter than the minimum length. All outputs are registered and describe the beat accepted at the previous clock edge.

Top module: `seg_frame_tracker`

## Requirements
- R1: After reset all outputs are zero and every channel is out of frame, so an end marker on any channel is then reported as an orphan end.
- R2: An enabled end-of-packet segment on a channel in frame sets `done_vld[i]` one cycle after the beat. `done_len[16*i +: 16]` then holds 16 times the count of enabled segments in the frame minus `seg_mty[4*i +: 4]` of that end segment.
- R3: Frame state is kept per channel (`in_chan`, 3 bits, 8 channels). A frame continues across later beats of the same channel, however many beats of other channels arrive in between.
- R4: Segments of one beat are evaluated in ascending index order. A beat may complete several frames, or end one frame and start another that continues beyond the beat.
- R5: Start and end markers on the same enabled segment form a one-segment frame of 16 minus its empty-byte count.
- R6: A completed frame shorter than 64 bytes pulses `err_runt`. A frame of exactly 64 bytes does not.
- R7: An enabled start marker on a channel already in frame pulses `err_dup_sop`. The old frame is dropped, and a new frame is counted from that segment.
- R8: An enabled end marker without a start marker on a channel out of frame pulses `err_orphan_eop` and reports no frame.
- R9: An enabled segment with neither marker on a channel out of frame pulses `err_stray_seg` and is not counted.
- R10: Segments with enable low are ignored, including their markers. A valid beat with all enables low changes no state and raises no output.
- R11: While `in_valid` is low, all channel state holds and all outputs are zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present |
| in_chan | input | 3 | Channel of the beat |
| seg_en | input | 12 | Per-segment enable |
| seg_sop | input | 12 | Per-segment start marker |
| seg_eop | input | 12 | Per-segment end marker |
| seg_mty | input | 48 | Empty bytes of each segment, 4 bits per segment |
| done_vld | output | 12 | Frame completed at this segment |
| done_len | output | 192 | Completed frame length in bytes, 16 bits per segment |
| err_dup_sop | output | 1 | Start while in frame |
| err_orphan_eop | output | 1 | End with no frame open |
| err_stray_seg | output | 1 | Data segment outside a frame |
| err_runt | output | 1 | Completed frame below minimum length |

## Verification
Closing a frame and opening the next one can happen in the same beat. So can a duplicate start and the close of the restarted frame in the following beat, and a runt flag together with a normal completion on another lane. The bench provokes these with beats that hold an end marker followed by a start marker, two start markers in one beat, and several back-to-back four-segment frames. It judges each result against a model that counts segments per channel and converts the count to bytes only when a frame closes, while comparing every lane's length and every flag.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int SEG_BYTES = 16;
  localparam int MTY_W     = 4;
  localparam int LEN_W     = 16;

  typedef logic [LEN_W-1:0] len_t;

  // Running length after one more full segment
  function automatic len_t seg_add(len_t acc);
    return acc + len_t'(SEG_BYTES);
  endfunction

  // Final length of a frame, given its full-segment byte total and end slack
  function automatic len_t frame_bytes(len_t acc, logic [MTY_W-1:0] mty);
    return acc - len_t'(mty);
  endfunction

  function automatic logic is_runt(len_t bytes, int min_bytes);
    return bytes < len_t'(min_bytes);
  endfunction
endpackage

// File: rtl/sft_lane.sv
module sft_lane
  import sft_pkg::*;
#(
  parameter int MIN_BYTES = 64
) (
  input  logic             en,
  input  logic             sop,
  input  logic             eop,
  input  logic [MTY_W-1:0] mty,
  input  logic             live_i,
  input  len_t             len_i,
  output logic             live_o,
  output len_t             len_o,
  output logic             done,
  output len_t             done_len,
  output logic             dup,
  output logic             orphan,
  output logic             stray,
  output logic             runt
);
  logic live;
  len_t acc;

  always_comb begin
    live     = live_i;
    acc      = len_i;
    dup      = 1'b0;
    orphan   = 1'b0;
    stray    = 1'b0;
    done     = 1'b0;
    done_len = '0;
    runt     = 1'b0;
    if (en) begin
      if (sop) begin
        dup  = live_i;
        live = 1'b1;
        acc  = len_t'(SEG_BYTES);
      end else if (live_i) begin
        acc = seg_add(len_i);
      end else if (eop) begin
        orphan = 1'b1;
      end else begin
        stray = 1'b1;
      end
      if (eop && live) begin
        done     = 1'b1;
        done_len = frame_bytes(acc, mty);
        runt     = is_runt(done_len, MIN_BYTES);
        live     = 1'b0;
        acc      = '0;
      end
    end
    live_o = live;
    len_o  = acc;
  end
endmodule

// File: rtl/sft_chan_store.sv
module sft_chan_store
  import sft_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] rd_ch,
  output logic            rd_live,
  output len_t            rd_len,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic            wr_live,
  input  len_t            wr_len
);
  logic [NCH-1:0] live_q;
  len_t [NCH-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      len_q  <= '0;
    end else if (wr_en) begin
      live_q[wr_ch] <= wr_live;
      len_q[wr_ch]  <= wr_len;
    end
  end

  assign rd_live = live_q[rd_ch];
  assign rd_len  = len_q[rd_ch];

  // R11: no write request, no change of any channel
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(live_q) && $stable(len_q)));
endmodule

// File: rtl/seg_frame_tracker.sv
module seg_frame_tracker
  import sft_pkg::*;
#(
  parameter int NSEG      = 12,
  parameter int NCH       = 8,
  parameter int MIN_BYTES = 64,
  localparam int CH_W     = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [CH_W-1:0]       in_chan,
  input  logic [NSEG-1:0]       seg_en,
  input  logic [NSEG-1:0]       seg_sop,
  input  logic [NSEG-1:0]       seg_eop,
  input  logic [NSEG*MTY_W-1:0] seg_mty,
  output logic [NSEG-1:0]       done_vld,
  output logic [NSEG*LEN_W-1:0] done_len,
  output logic                  err_dup_sop,
  output logic                  err_orphan_eop,
  output logic                  err_stray_seg,
  output logic                  err_runt
);
  logic                  live_c [NSEG+1];
  len_t                  len_c  [NSEG+1];
  logic [NSEG-1:0]       done_w, dup_w, orphan_w, stray_w, runt_w;
  logic [NSEG*LEN_W-1:0] dlen_w;

  sft_chan_store #(.NCH(NCH), .CH_W(CH_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .rd_ch(in_chan), .rd_live(live_c[0]), .rd_len(len_c[0]),
    .wr_en(in_valid), .wr_ch(in_chan),
    .wr_live(live_c[NSEG]), .wr_len(len_c[NSEG])
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_lane
    len_t lane_len;
    sft_lane #(.MIN_BYTES(MIN_BYTES)) lane_i (
      .en(seg_en[g]), .sop(seg_sop[g]), .eop(seg_eop[g]),
      .mty(seg_mty[g*MTY_W +: MTY_W]),
      .live_i(live_c[g]), .len_i(len_c[g]),
      .live_o(live_c[g+1]), .len_o(len_c[g+1]),
      .done(done_w[g]), .done_len(lane_len),
      .dup(dup_w[g]), .orphan(orphan_w[g]), .stray(stray_w[g]), .runt(runt_w[g])
    );
    assign dlen_w[g*LEN_W +: LEN_W] = lane_len;

    // R9: a lane reports at most one kind of fault
    assert_one_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dup_w[g], orphan_w[g], stray_w[g]}));
    // R2: a reported frame is never empty
    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld[g] |-> (done_len[g*LEN_W +: LEN_W] != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !in_valid) begin
      done_vld       <= '0;
      done_len       <= '0;
      err_dup_sop    <= 1'b0;
      err_orphan_eop <= 1'b0;
      err_stray_seg  <= 1'b0;
      err_runt       <= 1'b0;
    end else begin
      done_vld       <= done_w;
      done_len       <= dlen_w;
      err_dup_sop    <= |dup_w;
      err_orphan_eop <= |orphan_w;
      err_stray_seg  <= |stray_w;
      err_runt       <= |runt_w;
    end
  end

  // R11: a gap beat leaves the outputs quiet
  assert_quiet_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (done_vld == '0 && !err_dup_sop && !err_orphan_eop
                   && !err_stray_seg && !err_runt));
  // R10: an all-disabled beat reports nothing
  assert_idle_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_en == '0) |=> (done_vld == '0 && !err_dup_sop
                   && !err_orphan_eop && !err_stray_seg && !err_runt));
  // R6: a runt is always a completed frame
  assert_runt_has_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_runt |-> (done_vld != '0));
endmodule

// File: tb/seg_frame_tracker_tb.sv
module seg_frame_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 12;
  localparam int NVEC = 16;

  // {valid, chan, en, sop, eop}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 12'hC00, 12'h400, 12'h000},
    {1'b1, 3'd0, 12'hFC0, 12'h040, 12'h800},
    {1'b1, 3'd1, 12'h00F, 12'h000, 12'h008},
    {1'b1, 3'd2, 12'hFFF, 12'h111, 12'h888},
    {1'b1, 3'd3, 12'hFCF, 12'h041, 12'h008},
    {1'b0, 3'd3, 12'hFFF, 12'h000, 12'h800},
    {1'b1, 3'd2, 12'h000, 12'h000, 12'h000},
    {1'b1, 3'd3, 12'h01F, 12'h000, 12'h010},
    {1'b1, 3'd0, 12'hFFF, 12'h801, 12'h400},
    {1'b1, 3'd0, 12'h003, 12'h002, 12'h000},
    {1'b1, 3'd0, 12'h001, 12'h000, 12'h001},
    {1'b1, 3'd5, 12'h00F, 12'h000, 12'h008},
    {1'b1, 3'd4, 12'h001, 12'h001, 12'h001},
    {1'b1, 3'd6, 12'h0F0, 12'h010, 12'h080},
    {1'b1, 3'd7, 12'h000, 12'hFFF, 12'hFFF},
    {1'b1, 3'd7, 12'h001, 12'h000, 12'h000}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [2:0]  in_chan = '0;
  logic [11:0] seg_en = '0, seg_sop = '0, seg_eop = '0;
  logic [47:0] seg_mty = '0;
  logic [11:0] done_vld;
  logic [191:0] done_len;
  logic err_dup_sop, err_orphan_eop, err_stray_seg, err_runt;

  int checks = 0;
  int errors = 0;

  // model: per-channel open flag and segment count
  bit  m_open [8];
  int  m_segs [8];
  bit [11:0] x_done;
  int  x_len [12];
  bit  x_dup, x_orph, x_stray, x_runt;

  seg_frame_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .seg_en(seg_en), .seg_sop(seg_sop), .seg_eop(seg_eop), .seg_mty(seg_mty),
    .done_vld(done_vld), .done_len(done_len),
    .err_dup_sop(err_dup_sop), .err_orphan_eop(err_orphan_eop),
    .err_stray_seg(err_stray_seg), .err_runt(err_runt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 8; c++) begin
      m_open[c] = 0;
      m_segs[c] = 0;
    end
  endtask

  task automatic model_beat(bit v, int ch, bit [11:0] en, bit [11:0] sop,
                            bit [11:0] eop, bit [47:0] mty);
    x_done = '0; x_dup = 0; x_orph = 0; x_stray = 0; x_runt = 0;
    for (int s = 0; s < 12; s++) x_len[s] = 0;
    if (!v) return;
    for (int s = 0; s < 12; s++) begin
      if (!en[s]) continue;
      if (sop[s]) begin
        if (m_open[ch]) x_dup = 1;
        m_open[ch] = 1;
        m_segs[ch] = 1;
      end else if (m_open[ch]) begin
        m_segs[ch]++;
      end else if (eop[s]) begin
        x_orph = 1;
      end else begin
        x_stray = 1;
      end
      if (eop[s] && m_open[ch]) begin
        x_done[s] = 1;
        x_len[s]  = m_segs[ch] * 16 - int'(mty[4*s +: 4]);
        if (x_len[s] < 64) x_runt = 1;
        m_open[ch] = 0;
        m_segs[ch] = 0;
      end
    end
  endtask

  task automatic apply(bit v, int ch, bit [11:0] en, bit [11:0] sop,
                       bit [11:0] eop, bit [47:0] mty, string req);
    model_beat(v, ch, en, sop, eop, mty);
    in_valid = v; in_chan = 3'(ch);
    seg_en = en; seg_sop = sop; seg_eop = eop; seg_mty = mty;
    @(posedge clk); #1;
    check(req, "done_vld", done_vld, x_done);
    for (int s = 0; s < 12; s++)
      if (x_done[s]) check(req, $sformatf("len seg%0d", s), done_len[16*s +: 16], x_len[s]);
    check(req, "err_dup_sop", err_dup_sop, x_dup);
    check(req, "err_orphan_eop", err_orphan_eop, x_orph);
    check(req, "err_stray_seg", err_stray_seg, x_stray);
    check(req, "err_runt", err_runt, x_runt);
  endtask

  function automatic string vec_tag(int k);
    case (k)
      0, 1, 2, 3, 4: return "R2 R3 R4";
      5:             return "R11";
      6:             return "R10";
      7:             return "R3";
      8:             return "R4";
      9:             return "R7";
      10:            return "R6";
      11:            return "R8 R9";
      12:            return "R5 R6";
      13:            return "R6";
      14:            return "R10";
      default:       return "R9 R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state of outputs
    check("R1", "done_vld after reset", done_vld, 0);
    check("R1", "flags after reset",
          {err_dup_sop, err_orphan_eop, err_stray_seg, err_runt}, 0);
    rst_n = 1;

    for (int k = 0; k < NVEC; k++)
      apply(VEC[k][39], int'(VEC[k][38:36]), VEC[k][35:24], VEC[k][23:12],
            VEC[k][11:0], '0, vec_tag(k));

    // R2 R6: empty bytes on the end segment; 80-15=65 is no runt
    apply(1, 6, 12'h01F, 12'h001, 12'h010, 48'hF << 16, "R2 R6");
    // R6: 64-1=63 is a runt
    apply(1, 6, 12'h00F, 12'h001, 12'h008, 48'h1 << 12, "R6");
    // R5: one-segment frame with slack 5 -> 11
    apply(1, 4, 12'h020, 12'h020, 12'h020, 48'h5 << 20, "R5");
    // R4 R7: dup start, then end and restart in one beat
    apply(1, 2, 12'h001, 12'h001, 12'h000, '0, "R4");
    apply(1, 2, 12'h0FF, 12'h012, 12'h008, '0, "R7");
    apply(1, 2, 12'h001, 12'h000, 12'h001, '0, "R4");

    // R1: reset clears frame state of channel 2
    apply(1, 2, 12'h001, 12'h001, 12'h000, '0, "R1");
    in_valid = 0;
    rst_n = 0;
    @(posedge clk); #1;
    model_clear();
    rst_n = 1;
    apply(1, 2, 12'h001, 12'h000, 12'h001, '0, "R1 R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule